// File: doc/BRIEF.md
# Scratch Pad RAM Access Controller

This block lets a host that talks in bytes use part of a shared external RAM as free-form scratch storage. The host opens an access with a command. The command gives the direction (write or read), the word width (8 or 12 bits), the addressing mode (one location only, or automatic row stepping) and a start address made of a quarter, a page, a column and a row. After the command, data moves one byte at a time. The controller turns each completed location into a single RAM request on a flat RAM address.

A 12-bit word travels as two bytes. The first byte carries bits 11..8 in its low nibble, and its high nibble is ignored. The second byte carries bits 7..0. Each quarter has its own geometry. The configured RAM type decides which quarters may be used. A command that points outside the legal space raises a sticky error and opens nothing.

During a slow-transfer window, bytes move only when a free slot is reported. The host sees this through a ready output that it polls.

Top module: `spad_ctrl`

## Requirements
- R1: In 8-bit write mode, each accepted byte `b` makes exactly one RAM write in the same cycle. Its data is `{4'b0000, b}` and its address is the current location.
- R2: In 12-bit write mode, the first accepted byte makes no RAM request, and only its bits 3..0 are kept. The second accepted byte makes one RAM write with data `{first[3:0], second}`.
- R3: In 8-bit read mode, an accepted read request makes one RAM read in the same cycle. `rd_valid` is high in the next cycle, with `rd_data` equal to bits 7..0 of the word returned by the RAM. The RAM returns its word one cycle after the request.
- R4: In 12-bit read mode, the first accepted request makes one RAM read and returns `{4'b0000, word[11:8]}`. The second request makes no RAM access and returns `word[7:0]`. Each byte arrives one cycle after its request.
- R5: The RAM address is `quarter*32768 + (page*C + k)*R + row`. For quarter 0, C=7, R=64 and k=column-1. For the other quarters, C=8, R=448 and k=column.
- R6: In single-location mode, `xfer_ready` drops after one location completes and stays low until the next command.
- R7: In auto-increment mode, the row advances by one after each completed location. Completing the location on the last row of the column (63 in quarter 0, 447 elsewhere) sets `eoc_flag` and drops `xfer_ready`. Further bytes are then ignored. A new command clears `eoc_flag`.
- R8: The legal quarters per `ram_type` code are:
  - codes 0, 2 and 4: quarter 0 only;
  - codes 1 and 3: quarters 0 to 3;
  - code 5: quarters 0 and 2;
  - codes 6 and 7: no quarter.
- R9: A command with an illegal quarter, a page above 5, a column out of range (column 0 in quarter 0) or a row beyond the quarter's last row sets `err_flag` and leaves `xfer_ready` low. No RAM request follows. `err_flag` stays set until reset.
- R10: While `slow_win` is high and `slot_free` is low, `xfer_ready` is low and data bytes and read requests are ignored. When `slot_free` is high they are accepted as usual.
- R11: After reset, `xfer_ready`, `err_flag`, `eoc_flag`, `ram_req` and `rd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ram_type | input | 3 | RAM type configuration code |
| slow_win | input | 1 | Slow-transfer window active |
| slot_free | input | 1 | A transfer slot is free inside the slow window |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_write | input | 1 | 1 = write access, 0 = read access |
| cmd_wide | input | 1 | 1 = 12-bit words, 0 = 8-bit words |
| cmd_auto | input | 1 | 1 = auto-increment, 0 = single location |
| cmd_quarter | input | 2 | Quarter of the start address |
| cmd_page | input | 3 | Page of the start address |
| cmd_col | input | 3 | Column of the start address |
| cmd_row | input | 9 | Row of the start address |
| wr_valid | input | 1 | Host offers a write byte |
| wr_data | input | 8 | Write byte |
| rd_req | input | 1 | Host requests a read byte |
| xfer_ready | output | 1 | A byte may move this cycle |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| ram_req | output | 1 | RAM access request |
| ram_we | output | 1 | RAM write enable (valid with `ram_req`) |
| ram_addr | output | 17 | Flat RAM address |
| ram_wdata | output | 12 | RAM write word |
| ram_rdata | input | 12 | RAM read word, one cycle after a read request |
| err_flag | output | 1 | Sticky illegal-access flag |
| eoc_flag | output | 1 | Auto-increment reached the end of its column |

## Verification
A seeded random run writes random words to random legal locations in every quarter, using both widths, and reads each one back. This separates errors in the address arithmetic, which show as a wrong address or stale data, from errors in nibble and byte packing. Directed runs sweep all eight RAM type codes against all four quarters, so that each entry of the legality table is told apart. They also probe each geometry edge just inside and just outside the legal range. Auto-increment runs that start two rows before the column end show the row step and the end-of-column stop. Slow-window runs with and without a free slot show that gating really holds back requests, including between the two bytes of a 12-bit word.

// File: rtl/spad_pkg.sv
package spad_pkg;
  parameter int TW      = 3;     // ram type code width
  parameter int QW      = 2;     // quarter field width
  parameter int PW      = 3;     // page field width
  parameter int CW      = 3;     // column field width
  parameter int RW      = 9;     // row field width
  parameter int BW      = 8;     // host byte width
  parameter int NW      = 4;     // upper part of a wide word
  parameter int WW      = BW + NW;
  parameter int QSH     = 15;    // quarter base = quarter << QSH
  parameter int AW      = QSH + QW;
  parameter int PAGES   = 6;
  parameter int Q0_COLS = 7;
  parameter int Q0_ROWS = 64;
  parameter int QN_COLS = 8;
  parameter int QN_ROWS = 448;

  typedef enum logic [1:0] {RK_NARROW, RK_HI, RK_LO} rd_kind_t;

  function automatic int rows_of(input logic [QW-1:0] q);
    return (q == '0) ? Q0_ROWS : QN_ROWS;
  endfunction

  function automatic int cols_of(input logic [QW-1:0] q);
    return (q == '0) ? Q0_COLS : QN_COLS;
  endfunction

  function automatic logic quarter_ok(input logic [TW-1:0] rt, input logic [QW-1:0] q);
    case (rt)
      3'd0, 3'd2, 3'd4: return q == '0;
      3'd1, 3'd3:       return 1'b1;
      3'd5:             return q[0] == 1'b0;
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic geom_ok(input logic [QW-1:0] q, input logic [PW-1:0] p,
                                   input logic [CW-1:0] c, input logic [RW-1:0] r);
    if (int'(p) >= PAGES) return 1'b0;
    if (q == '0) begin
      if (c == '0 || int'(c) > cols_of(q)) return 1'b0;
    end else if (int'(c) >= cols_of(q)) return 1'b0;
    return int'(r) < rows_of(q);
  endfunction

  function automatic logic [AW-1:0] lin_addr(input logic [QW-1:0] q, input logic [PW-1:0] p,
                                             input logic [CW-1:0] c, input logic [RW-1:0] r);
    int k;
    int v;
    k = (q == '0) ? int'(c) - 1 : int'(c);
    v = (int'(q) << QSH) + (int'(p) * cols_of(q) + k) * rows_of(q) + int'(r);
    return v[AW-1:0];
  endfunction
endpackage

// File: rtl/spad_geom.sv
module spad_geom
  import spad_pkg::*;
(
  input  logic [QW-1:0] quarter,
  input  logic [PW-1:0] page,
  input  logic [CW-1:0] col,
  input  logic [RW-1:0] row,
  output logic [AW-1:0] lin,
  output logic          last_row
);
  always_comb begin
    lin      = lin_addr(quarter, page, col, row);
    last_row = (int'(row) == rows_of(quarter) - 1);
  end
endmodule

// File: rtl/spad_pack.sv
module spad_pack
  import spad_pkg::*;
(
  input  logic          wide,
  input  logic [NW-1:0] nib,
  input  logic [BW-1:0] wr_byte,
  output logic [WW-1:0] wdata,
  input  rd_kind_t      kind,
  input  logic [WW-1:0] ram_word,
  input  logic [BW-1:0] lo_byte,
  output logic [BW-1:0] rd_byte
);
  always_comb begin
    wdata = wide ? {nib, wr_byte} : {{NW{1'b0}}, wr_byte};
    case (kind)
      RK_HI:   rd_byte = {{(BW-NW){1'b0}}, ram_word[WW-1:BW]};
      RK_LO:   rd_byte = lo_byte;
      default: rd_byte = ram_word[BW-1:0];
    endcase
  end
endmodule

// File: rtl/spad_ctrl.sv
module spad_ctrl
  import spad_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] ram_type,
  input  logic          slow_win,
  input  logic          slot_free,
  input  logic          cmd_valid,
  input  logic          cmd_write,
  input  logic          cmd_wide,
  input  logic          cmd_auto,
  input  logic [QW-1:0] cmd_quarter,
  input  logic [PW-1:0] cmd_page,
  input  logic [CW-1:0] cmd_col,
  input  logic [RW-1:0] cmd_row,
  input  logic          wr_valid,
  input  logic [BW-1:0] wr_data,
  input  logic          rd_req,
  output logic          xfer_ready,
  output logic          rd_valid,
  output logic [BW-1:0] rd_data,
  output logic          ram_req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [WW-1:0] ram_wdata,
  input  logic [WW-1:0] ram_rdata,
  output logic          err_flag,
  output logic          eoc_flag
);
  logic          active_q, wr_q, wide_q, auto_q, eoc_q, err_q, phase_q, rd_pend_q;
  rd_kind_t      rd_kind_q;
  logic [QW-1:0] q_q;
  logic [PW-1:0] page_q;
  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic [NW-1:0] nib_q;
  logic [BW-1:0] lo_q;

  // named internal events
  logic cmd_ok, wr_acc, rd_acc, byte_acc, loc_done, last_row;

  assign cmd_ok     = quarter_ok(ram_type, cmd_quarter) &&
                      geom_ok(cmd_quarter, cmd_page, cmd_col, cmd_row);
  assign xfer_ready = active_q & ~eoc_q & ~rd_pend_q & (~slow_win | slot_free);
  assign wr_acc     = ~cmd_valid & xfer_ready & wr_q & wr_valid;
  assign rd_acc     = ~cmd_valid & xfer_ready & ~wr_q & rd_req;
  assign byte_acc   = wr_acc | rd_acc;
  assign loc_done   = byte_acc & (~wide_q | phase_q);
  assign ram_req    = (wr_acc & (~wide_q | phase_q)) | (rd_acc & (~wide_q | ~phase_q));
  assign ram_we     = wr_q;
  assign rd_valid   = rd_pend_q;
  assign err_flag   = err_q;
  assign eoc_flag   = eoc_q;

  spad_geom u_geom (
    .quarter (q_q),
    .page    (page_q),
    .col     (col_q),
    .row     (row_q),
    .lin     (ram_addr),
    .last_row(last_row)
  );

  spad_pack u_pack (
    .wide    (wide_q),
    .nib     (nib_q),
    .wr_byte (wr_data),
    .wdata   (ram_wdata),
    .kind    (rd_kind_q),
    .ram_word(ram_rdata),
    .lo_byte (lo_q),
    .rd_byte (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      wr_q      <= 1'b0;
      wide_q    <= 1'b0;
      auto_q    <= 1'b0;
      eoc_q     <= 1'b0;
      err_q     <= 1'b0;
      phase_q   <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_kind_q <= RK_NARROW;
      q_q       <= '0;
      page_q    <= '0;
      col_q     <= '0;
      row_q     <= '0;
      nib_q     <= '0;
      lo_q      <= '0;
    end else begin
      rd_pend_q <= rd_acc;
      if (rd_acc)
        rd_kind_q <= !wide_q ? RK_NARROW : (phase_q ? RK_LO : RK_HI);
      if (rd_pend_q && rd_kind_q == RK_HI)
        lo_q <= ram_rdata[BW-1:0];
      if (cmd_valid) begin
        err_q    <= err_q | ~cmd_ok;
        active_q <= cmd_ok;
        wr_q     <= cmd_write;
        wide_q   <= cmd_wide;
        auto_q   <= cmd_auto;
        q_q      <= cmd_quarter;
        page_q   <= cmd_page;
        col_q    <= cmd_col;
        row_q    <= cmd_row;
        eoc_q    <= 1'b0;
        phase_q  <= 1'b0;
      end else if (byte_acc) begin
        if (wr_acc && wide_q && !phase_q)
          nib_q <= wr_data[NW-1:0];
        if (loc_done) begin
          phase_q <= 1'b0;
          if (!auto_q)
            active_q <= 1'b0;
          else if (last_row)
            eoc_q <= 1'b1;
          else
            row_q <= row_q + 1'b1;
        end else begin
          phase_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spad_ctrl_chk.sv
module spad_ctrl_chk
  import spad_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          slow_win,
  input logic          slot_free,
  input logic          cmd_valid,
  input logic          cmd_ok,
  input logic          loc_done,
  input logic          auto_q,
  input logic          xfer_ready,
  input logic          rd_valid,
  input logic          ram_req,
  input logic          ram_we,
  input logic [AW-1:0] ram_addr,
  input logic          err_flag,
  input logic          eoc_flag
);
  localparam int Q0_SIZE = PAGES * Q0_COLS * Q0_ROWS;
  localparam int QN_SIZE = PAGES * QN_COLS * QN_ROWS;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R9
  AST_BAD_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ok) |=> (!xfer_ready && err_flag)); // R9
  AST_SLOW_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> (!slow_win || slot_free)); // R10
  AST_EOC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_flag |-> (!ram_req && !xfer_ready)); // R7
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_req && !ram_we) |=> rd_valid); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req |-> (int'(ram_addr[QSH-1:0]) < ((ram_addr[AW-1:QSH] == '0) ? Q0_SIZE : QN_SIZE))); // R5
  AST_SINGLE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_done && !auto_q) |=> !xfer_ready); // R6
endmodule

bind spad_ctrl spad_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .slow_win  (slow_win),
  .slot_free (slot_free),
  .cmd_valid (cmd_valid),
  .cmd_ok    (cmd_ok),
  .loc_done  (loc_done),
  .auto_q    (auto_q),
  .xfer_ready(xfer_ready),
  .rd_valid  (rd_valid),
  .ram_req   (ram_req),
  .ram_we    (ram_we),
  .ram_addr  (ram_addr),
  .err_flag  (err_flag),
  .eoc_flag  (eoc_flag)
);

// File: tb/spad_ctrl_tb.sv
module spad_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ram_type = 3'd1;
  logic        slow_win = 1'b0, slot_free = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_wide = 1'b0, cmd_auto = 1'b0;
  logic [1:0]  cmd_quarter = '0;
  logic [2:0]  cmd_page = '0, cmd_col = '0;
  logic [8:0]  cmd_row = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        rd_req = 1'b0;
  logic        xfer_ready, rd_valid, ram_req, ram_we, err_flag, eoc_flag;
  logic [7:0]  rd_data;
  logic [16:0] ram_addr;
  logic [11:0] ram_wdata;
  logic [11:0] ram_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spad_ctrl dut_i (.*);

  // external RAM model: one-cycle read latency
  logic [11:0] mem [int];
  logic [11:0] shadow [int];

  function automatic logic [11:0] pat(input int a);
    int v;
    v = a * 37 + 5;
    return v[11:0];
  endfunction

  always @(posedge clk) begin
    if (ram_req && !ram_we)
      ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : pat(int'(ram_addr));
    if (ram_req && ram_we)
      mem[int'(ram_addr)] = ram_wdata;
  end

  function automatic int exp_addr(input int q, input int p, input int c, input int r);
    if (q == 0) return r + 64 * ((c - 1) + 7 * p);
    return q * 32768 + r + 448 * (c + 8 * p);
  endfunction

  function automatic logic [11:0] exp_word(input int a);
    return shadow.exists(a) ? shadow[a] : pat(a);
  endfunction

  function automatic bit legal_q(input int rt, input int q);
    logic [3:0] m;
    case (rt)
      1, 3:    m = 4'b1111;
      5:       m = 4'b0101;
      0, 2, 4: m = 4'b0001;
      default: m = 4'b0000;
    endcase
    return m[q];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_cmd(input bit wr, input bit wide, input bit au, input int q,
                          input int p, input int c, input int r);
    cmd_write = wr; cmd_wide = wide; cmd_auto = au;
    cmd_quarter = q[1:0]; cmd_page = p[2:0]; cmd_col = c[2:0]; cmd_row = r[8:0];
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, output bit req, output int addr, output int wd);
    wr_valid = 1'b1; wr_data = b;
    #1;
    req = ram_req && ram_we; addr = int'(ram_addr); wd = int'(ram_wdata);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic get_byte(output bit req, output int addr, output bit vld, output logic [7:0] d);
    rd_req = 1'b1;
    #1;
    req = ram_req && !ram_we; addr = int'(ram_addr);
    @(negedge clk);
    rd_req = 1'b0;
    #1;
    vld = rd_valid; d = rd_data;
    @(negedge clk);
  endtask

  // write one location in single-location mode and check the RAM side
  task automatic write_loc(input int q, input int p, input int c, input int r,
                           input bit wide, input logic [11:0] w);
    bit req; int addr, wd, a; logic [7:0] hi;
    a = exp_addr(q, p, c, r);
    send_cmd(1'b1, wide, 1'b0, q, p, c, r);
    if (wide) begin
      hi = {4'($urandom), w[11:8]};
      put_byte(hi, req, addr, wd);
      chk(!req, "R2 first byte makes no RAM write", int'(req), 0);
      put_byte(w[7:0], req, addr, wd);
      chk(req && wd == int'(w), "R2 wide write data", wd, int'(w));
      shadow[a] = w;
    end else begin
      put_byte(w[7:0], req, addr, wd);
      chk(req && wd == int'(w[7:0]), "R1 narrow write data", wd, int'(w[7:0]));
      shadow[a] = {4'b0, w[7:0]};
    end
    chk(addr == a, "R5 write address", addr, a);
    chk(!xfer_ready, "R6 ready low after single location", int'(xfer_ready), 0);
  endtask

  task automatic read_loc(input int q, input int p, input int c, input int r, input bit wide);
    bit req, vld; int addr, a; logic [7:0] d; logic [11:0] e;
    a = exp_addr(q, p, c, r);
    e = exp_word(a);
    send_cmd(1'b0, wide, 1'b0, q, p, c, r);
    get_byte(req, addr, vld, d);
    chk(req && addr == a, "R5 read address", addr, a);
    if (wide) begin
      chk(vld && d == {4'b0, e[11:8]}, "R4 wide read upper byte", int'(d), int'(e[11:8]));
      get_byte(req, addr, vld, d);
      chk(!req, "R4 second byte makes no RAM read", int'(req), 0);
      chk(vld && d == e[7:0], "R4 wide read lower byte", int'(d), int'(e[7:0]));
    end else begin
      chk(vld && d == e[7:0], "R3 narrow read byte", int'(d), int'(e[7:0]));
    end
    chk(!xfer_ready, "R6 ready low after single read", int'(xfer_ready), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit req, vld; int addr, wd; logic [7:0] d;
    void'($urandom(32'd20231));
    #1;
    chk(!xfer_ready && !err_flag && !eoc_flag && !ram_req && !rd_valid,
        "R11 reset state", {xfer_ready, err_flag, eoc_flag, ram_req, rd_valid}, 0);
    do_reset();
    chk(!xfer_ready && !err_flag && !eoc_flag, "R11 idle after reset",
        {xfer_ready, err_flag, eoc_flag}, 0);

    // directed corner locations
    ram_type = 3'd1;
    write_loc(0, 5, 7, 63, 1'b1, 12'hABC);
    read_loc(0, 5, 7, 63, 1'b1);
    write_loc(3, 5, 7, 447, 1'b0, 12'h05A);
    read_loc(3, 5, 7, 447, 1'b0);
    write_loc(1, 0, 0, 0, 1'b1, 12'hF00);
    read_loc(1, 0, 0, 0, 1'b1);

    // random legal traffic
    for (int i = 0; i < 150; i++) begin
      int q, p, c, r; bit wide; logic [11:0] w;
      q = int'($urandom % 4); p = int'($urandom % 6);
      c = (q == 0) ? 1 + int'($urandom % 7) : int'($urandom % 8);
      r = (q == 0) ? int'($urandom % 64) : int'($urandom % 448);
      wide = 1'($urandom); w = 12'($urandom);
      if ((i % 5) != 4) write_loc(q, p, c, r, wide, w);
      read_loc(q, p, c, r, 1'($urandom));
    end

    // R8 legality table
    for (int rt = 0; rt < 8; rt++) begin
      for (int q = 0; q < 4; q++) begin
        do_reset();
        ram_type = rt[2:0];
        send_cmd(1'b0, 1'b0, 1'b0, q, 0, (q == 0) ? 1 : 0, 0);
        chk(xfer_ready == legal_q(rt, q), $sformatf("R8 type %0d quarter %0d ready", rt, q),
            int'(xfer_ready), int'(legal_q(rt, q)));
        chk(err_flag == !legal_q(rt, q), $sformatf("R8 type %0d quarter %0d error", rt, q),
            int'(err_flag), int'(!legal_q(rt, q)));
      end
    end

    // R9 geometry limits
    ram_type = 3'd1;
    for (int k = 0; k < 4; k++) begin
      int q, p, c, r;
      case (k)
        0: begin q = 0; p = 0; c = 0; r = 0;   end
        1: begin q = 2; p = 6; c = 0; r = 0;   end
        2: begin q = 1; p = 0; c = 0; r = 448; end
        default: begin q = 0; p = 1; c = 3; r = 64; end
      endcase
      do_reset();
      send_cmd(1'b1, 1'b0, 1'b0, q, p, c, r);
      chk(err_flag && !xfer_ready, $sformatf("R9 illegal case %0d flags", k),
          {err_flag, xfer_ready}, 2);
      put_byte(8'h55, req, addr, wd);
      chk(!req, $sformatf("R9 illegal case %0d no RAM write", k), int'(req), 0);
    end
    send_cmd(1'b0, 1'b0, 1'b0, 2, 0, 0, 0);
    chk(err_flag && xfer_ready, "R9 error sticky over legal command", {err_flag, xfer_ready}, 3);

    // R7 auto-increment to column end
    do_reset();
    send_cmd(1'b1, 1'b0, 1'b1, 0, 0, 1, 62);
    put_byte(8'h11, req, addr, wd);
    chk(req && addr == exp_addr(0, 0, 1, 62), "R7 auto first row", addr, exp_addr(0, 0, 1, 62));
    chk(xfer_ready && !eoc_flag, "R7 still open before last row", {xfer_ready, eoc_flag}, 2);
    put_byte(8'h22, req, addr, wd);
    chk(req && addr == exp_addr(0, 0, 1, 63), "R7 auto second row", addr, exp_addr(0, 0, 1, 63));
    chk(eoc_flag && !xfer_ready, "R7 end of column flag", {eoc_flag, xfer_ready}, 2);
    put_byte(8'h33, req, addr, wd);
    chk(!req, "R7 byte after column end ignored", int'(req), 0);
    shadow[exp_addr(0, 0, 1, 62)] = 12'h011;
    shadow[exp_addr(0, 0, 1, 63)] = 12'h022;
    send_cmd(1'b0, 1'b0, 1'b1, 0, 0, 1, 62);
    chk(!eoc_flag && xfer_ready, "R7 new command clears end flag", {eoc_flag, xfer_ready}, 1);
    for (int r = 62; r < 64; r++) begin
      get_byte(req, addr, vld, d);
      chk(vld && d == exp_word(exp_addr(0, 0, 1, r)) && addr == exp_addr(0, 0, 1, r),
          "R7 auto read back", int'(d), int'(exp_word(exp_addr(0, 0, 1, r))));
    end
    chk(eoc_flag, "R7 end flag after auto read", int'(eoc_flag), 1);
    send_cmd(1'b1, 1'b1, 1'b1, 2, 1, 3, 446);
    for (int r = 446; r < 448; r++) begin
      put_byte(8'h07, req, addr, wd);
      chk(!req, "R2 auto wide first byte", int'(req), 0);
      put_byte(r[7:0], req, addr, wd);
      chk(req && addr == exp_addr(2, 1, 3, r) && wd == {4'h7, r[7:0]},
          "R7 auto wide row", addr, exp_addr(2, 1, 3, r));
    end
    chk(eoc_flag, "R7 end flag in quarter 2", int'(eoc_flag), 1);

    // R10 slow window gating
    do_reset();
    slow_win = 1'b1; slot_free = 1'b0;
    send_cmd(1'b1, 1'b1, 1'b0, 1, 2, 4, 100);
    chk(!xfer_ready, "R10 ready low without slot", int'(xfer_ready), 0);
    put_byte(8'h0C, req, addr, wd);
    chk(!req, "R10 byte held back", int'(req), 0);
    slot_free = 1'b1;
    #1;
    chk(xfer_ready, "R10 ready with free slot", int'(xfer_ready), 1);
    put_byte(8'h0D, req, addr, wd);
    slot_free = 1'b0;
    put_byte(8'hEE, req, addr, wd);
    chk(!req, "R10 second byte held back", int'(req), 0);
    slot_free = 1'b1;
    put_byte(8'h42, req, addr, wd);
    chk(req && wd == 12'hD42 && addr == exp_addr(1, 2, 4, 100), "R10 word after gap", wd, 12'hD42);
    shadow[exp_addr(1, 2, 4, 100)] = 12'hD42;
    slow_win = 1'b0;
    read_loc(1, 2, 4, 100, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule